// File: doc/BRIEF.md
# Elastic Two-Rail Bit Store with Near-Limit Flag

This block is a per-channel elastic store that sits between a jittery recovered write clock and a smoothed read clock. Each stored entry is one bit of positive-rail data and one bit of negative-rail data. Incoming bits are captured on a chosen edge of the write clock and presented at the output on a chosen edge of the read clock, so the store absorbs phase wander between the two. Both clocks arrive as ordinary level signals that are sampled in a single system clock domain; the block detects their edges itself.

The working depth is chosen at run time as the small or the large depth. A sticky flag warns when the fill level comes close to either end; software or a control pulse clears it. Reset, and any change of the depth select, put the store back at half full instead of emptying it. A bypass input routes the input rails and the write clock straight to the outputs with no buffering.

Top module: `bit_elastic_store`

## Requirements
- R1: The working depth is 16 entries while `size_large` is 0 and 32 entries while it is 1; writes beyond the working depth are not stored.
- R2: `limit_flag` is set when the fill level is 2 or less, or is the working depth minus 2 or more; it appears one clock after the fill level reaches that range.
- R3: A high pulse on `limit_clr` clears `limit_flag` when the fill level is outside the near-limit range; when the fill level is still inside it, the flag stays set. Without a clear the flag stays set after the fill level leaves the range.
- R4: A high pulse on `status_rd` clears `limit_flag` in the same way as `limit_clr`, and reset clears it.
- R5: After reset the store holds half the working depth of entries, each reading as positive 0 and negative 0, and the data outputs are 0.
- R6: A change of `size_large` re-centres the store to half of the new working depth; the next write lands behind exactly that many entries.
- R7: A write while the store is full is dropped: the stored contents and order are unchanged and `limit_flag` stays set.
- R8: A read while the store is empty is dropped: `out_pos`/`out_neg` keep their previous values and `limit_flag` stays set.
- R9: While `bypass` is 1, `out_pos`, `out_neg` and `out_clk` equal `wr_pos`, `wr_neg` and `wr_clk_in`, and write and read clock edges neither store nor remove entries.
- R10: With `wr_on_rise` = 1 the rails are captured on the rising edge of `wr_clk_in`; with 0 they are captured on its falling edge.
- R11: With `rd_on_rise` = 1 the output rails change on the rising edge of `rd_clk_in`; with 0 they change on its falling edge. Outside bypass `out_clk` follows `rd_clk_in`.
- R12: Entries leave the store in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock in which both line clocks are sampled |
| rst | input | 1 | Synchronous active-high reset; re-centres the store and clears the flag |
| wr_clk_in | input | 1 | Recovered (jittery) write clock level |
| wr_pos | input | 1 | Positive-rail input bit |
| wr_neg | input | 1 | Negative-rail input bit |
| wr_on_rise | input | 1 | 1: capture on rising write-clock edge, 0: on falling edge |
| rd_clk_in | input | 1 | Smoothed read clock level |
| rd_on_rise | input | 1 | 1: update outputs on rising read-clock edge, 0: on falling edge |
| size_large | input | 1 | Depth select: 0 for 16 entries, 1 for 32 entries |
| bypass | input | 1 | 1: route input rails and write clock straight to the outputs |
| limit_clr | input | 1 | Pulse high to clear the near-limit flag |
| status_rd | input | 1 | Status-read strobe; also clears the near-limit flag |
| out_clk | output | 1 | Output clock: read clock, or write clock in bypass |
| out_pos | output | 1 | Positive-rail output bit |
| out_neg | output | 1 | Negative-rail output bit |
| limit_flag | output | 1 | Sticky near-limit flag |

## Verification
The bench builds the block with its defaults: depths of 16 and 32 and a margin of 2 entries. With those values a reset leaves only 6 writes to the upper threshold and 6 reads to the lower one, so both flag thresholds, the full and empty drops and a complete wrap of the pointers at either depth fall within a few dozen line-clock edges. Switching to the large depth mid-run then shows the re-centre point through the exact number of reads that precede newly written data.

// File: rtl/bes_pkg.sv
package bes_pkg;

    // One stored entry: both rails of a single bit period
    typedef struct packed {
        logic pos;
        logic neg;
    } rail_t;

    // Working depth for the current size select
    function automatic int unsigned pick_depth(input logic big,
                                               input int unsigned small_d,
                                               input int unsigned large_d);
        return big ? large_d : small_d;
    endfunction

    // Edge of interest on a sampled line clock
    function automatic logic edge_hit(input logic now_lvl,
                                      input logic old_lvl,
                                      input logic on_rise);
        return on_rise ? (now_lvl & ~old_lvl) : (~now_lvl & old_lvl);
    endfunction

endpackage

// File: rtl/bes_edge_pick.sv
module bes_edge_pick (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic on_rise,
    output logic hit
);
    import bes_pkg::*;

    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign hit = edge_hit(lvl, lvl_q, on_rise);

endmodule

// File: rtl/bes_limit_flag.sv
module bes_limit_flag #(
    parameter int unsigned CW     = 6,
    parameter int unsigned MARGIN = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] fill,
    input  logic [CW-1:0] depth,
    input  logic          clr_pulse,
    input  logic          stat_rd,
    output logic          flag
);
    localparam logic [CW-1:0] MG = CW'(MARGIN);

    logic near;

    assign near = (fill <= MG) || (fill >= depth - MG);

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= near | (flag & ~(clr_pulse | stat_rd));
    end

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
        near |=> flag);  // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_pulse && !stat_rd) |=> flag);  // R3

endmodule

// File: rtl/bes_core.sv
module bes_core #(
    parameter int unsigned SMALL_DEPTH = 16,
    parameter int unsigned LARGE_DEPTH = 32,
    parameter int unsigned AW          = 5,
    parameter int unsigned CW          = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            size_large,
    input  logic            bypass,
    input  logic            wr_hit,
    input  logic            rd_hit,
    input  bes_pkg::rail_t  wr_data,
    output bes_pkg::rail_t  rd_data,
    output logic [CW-1:0]   fill,
    output logic [CW-1:0]   depth_cur
);
    import bes_pkg::*;

    rail_t         mem [LARGE_DEPTH];
    rail_t         out_q;
    logic [AW-1:0] wptr, rptr;
    logic          size_q;
    logic [CW-1:0] depth_new;
    logic          recentre;
    logic          do_wr, do_rd;

    assign depth_cur = CW'(pick_depth(size_q,     SMALL_DEPTH, LARGE_DEPTH));
    assign depth_new = CW'(pick_depth(size_large, SMALL_DEPTH, LARGE_DEPTH));
    assign recentre  = (size_large != size_q);
    assign do_wr     = !bypass && wr_hit && (fill < depth_cur);
    assign do_rd     = !bypass && rd_hit && (fill != '0);
    assign rd_data   = out_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p,
                                           input logic [CW-1:0] d);
        return (p == AW'(d - 1'b1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || recentre) begin
            wptr   <= AW'(depth_new >> 1);
            rptr   <= '0;
            fill   <= depth_new >> 1;
            size_q <= size_large;
            if (rst) begin
                out_q <= '0;
                for (int i = 0; i < int'(LARGE_DEPTH); i++) mem[i] <= '0;
            end
        end else begin
            if (do_wr) begin
                mem[wptr] <= wr_data;
                wptr      <= step(wptr, depth_cur);
            end
            if (do_rd) begin
                out_q <= mem[rptr];
                rptr  <= step(rptr, depth_cur);
            end
            case ({do_wr, do_rd})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fill <= depth_cur);  // R1
    AST_RECENTRE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fill == (depth_cur >> 1)));  // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (!recentre && !bypass && wr_hit && !rd_hit && fill == depth_cur)
        |=> $stable(fill));  // R7
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!recentre && !bypass && rd_hit && fill == '0) |=> $stable(out_q));  // R8
    AST_BYPASS_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (bypass && !recentre) |=> $stable(fill));  // R9

endmodule

// File: rtl/bit_elastic_store.sv
module bit_elastic_store #(
    parameter int unsigned SMALL_DEPTH = 16,
    parameter int unsigned LARGE_DEPTH = 32,
    parameter int unsigned MARGIN      = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_clk_in,
    input  logic wr_pos,
    input  logic wr_neg,
    input  logic wr_on_rise,
    input  logic rd_clk_in,
    input  logic rd_on_rise,
    input  logic size_large,
    input  logic bypass,
    input  logic limit_clr,
    input  logic status_rd,
    output logic out_clk,
    output logic out_pos,
    output logic out_neg,
    output logic limit_flag
);
    import bes_pkg::*;

    localparam int unsigned AW = $clog2(LARGE_DEPTH);
    localparam int unsigned CW = $clog2(LARGE_DEPTH + 1);

    logic          wr_hit, rd_hit;
    rail_t         wr_data, rd_data;
    logic [CW-1:0] fill, depth_cur;

    assign wr_data = '{pos: wr_pos, neg: wr_neg};

    bes_edge_pick u_wr_edge (
        .clk(clk), .rst(rst), .lvl(wr_clk_in), .on_rise(wr_on_rise), .hit(wr_hit)
    );
    bes_edge_pick u_rd_edge (
        .clk(clk), .rst(rst), .lvl(rd_clk_in), .on_rise(rd_on_rise), .hit(rd_hit)
    );

    bes_core #(
        .SMALL_DEPTH(SMALL_DEPTH), .LARGE_DEPTH(LARGE_DEPTH), .AW(AW), .CW(CW)
    ) u_core (
        .clk(clk), .rst(rst), .size_large(size_large), .bypass(bypass),
        .wr_hit(wr_hit), .rd_hit(rd_hit), .wr_data(wr_data), .rd_data(rd_data),
        .fill(fill), .depth_cur(depth_cur)
    );

    bes_limit_flag #(.CW(CW), .MARGIN(MARGIN)) u_flag (
        .clk(clk), .rst(rst), .fill(fill), .depth(depth_cur),
        .clr_pulse(limit_clr), .stat_rd(status_rd), .flag(limit_flag)
    );

    assign out_clk = bypass ? wr_clk_in : rd_clk_in;
    assign out_pos = bypass ? wr_pos    : rd_data.pos;
    assign out_neg = bypass ? wr_neg    : rd_data.neg;

endmodule

// File: tb/bit_elastic_store_tb.sv
module bit_elastic_store_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wclk = 1'b0, dpos = 1'b0, dneg = 1'b0, in_rise = 1'b1;
    logic rclk = 1'b0, out_rise = 1'b1, big = 1'b0, byp = 1'b0;
    logic clr = 1'b0, srd = 1'b0;
    logic oclk, opos, oneg, flag;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bit_elastic_store u_dut (
        .clk(clk), .rst(rst), .wr_clk_in(wclk), .wr_pos(dpos), .wr_neg(dneg),
        .wr_on_rise(in_rise), .rd_clk_in(rclk), .rd_on_rise(out_rise),
        .size_large(big), .bypass(byp), .limit_clr(clr), .status_rd(srd),
        .out_clk(oclk), .out_pos(opos), .out_neg(oneg), .limit_flag(flag)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
    endtask

    task automatic wr(input logic p, input logic n);
        @(negedge clk) begin dpos = p; dneg = n; wclk = 1'b1; end
        @(negedge clk) wclk = 1'b0;
        idle(2);
    endtask

    task automatic rd();
        @(negedge clk) rclk = 1'b1;
        @(negedge clk) rclk = 1'b0;
        idle(2);
    endtask

    task automatic pulse_clr(input logic use_status);
        @(negedge clk) begin clr = !use_status; srd = use_status; end
        @(negedge clk) begin clr = 1'b0; srd = 1'b0; end
        idle(1);
    endtask

    // Scenario: reset state and depth-16 fill, order, full and empty drops
    task automatic t_depth16();
        do_reset();
        check("R5 flag after reset", {1'b0, flag}, 2'b00);
        check("R5 outputs after reset", {opos, oneg}, 2'b00);
        for (int i = 0; i < 5; i++) wr(i[0], i[1]);
        check("R2 fill 13 no flag", {1'b0, flag}, 2'b00);
        wr(1'b1, 1'b0);
        check("R2 fill 14 flag", {1'b0, flag}, 2'b01);
        wr(1'b1, 1'b1);
        wr(1'b1, 1'b1);
        wr(1'b0, 1'b0);                         // dropped: store full
        check("R7 flag held when full", {1'b0, flag}, 2'b01);
        for (int i = 0; i < 8; i++) rd();
        check("R5 centre entries zero", {opos, oneg}, 2'b00);
        rd(); check("R12 entry 0", {opos, oneg}, 2'b00);
        rd(); check("R12 entry 1", {opos, oneg}, 2'b10);
        rd(); check("R12 entry 2", {opos, oneg}, 2'b01);
        rd(); check("R12 entry 3", {opos, oneg}, 2'b11);
        rd(); check("R12 entry 4", {opos, oneg}, 2'b00);
        rd(); check("R12 entry 5", {opos, oneg}, 2'b10);
        rd(); check("R12 entry 6", {opos, oneg}, 2'b11);
        rd(); check("R7 last kept entry, R1 depth 16", {opos, oneg}, 2'b11);
        rd();                                   // dropped: store empty
        check("R8 output held on empty read", {opos, oneg}, 2'b11);
        check("R8 flag held when empty", {1'b0, flag}, 2'b01);
        wr(1'b1, 1'b0);
        rd();
        check("R8 store intact after empty read", {opos, oneg}, 2'b10);
    endtask

    // Scenario: lower threshold and the three clear paths
    task automatic t_flag_clear();
        do_reset();
        for (int i = 0; i < 5; i++) rd();
        check("R2 fill 3 no flag", {1'b0, flag}, 2'b00);
        rd();
        check("R2 fill 2 flag", {1'b0, flag}, 2'b01);
        pulse_clr(1'b0);
        check("R3 clear while near re-sets", {1'b0, flag}, 2'b01);
        wr(1'b0, 1'b0);
        check("R3 flag sticky at fill 3", {1'b0, flag}, 2'b01);
        pulse_clr(1'b0);
        check("R3 clear pulse", {1'b0, flag}, 2'b00);
        rd();
        wr(1'b0, 1'b0);
        check("R4 flag before status read", {1'b0, flag}, 2'b01);
        pulse_clr(1'b1);
        check("R4 status read clears", {1'b0, flag}, 2'b00);
        rd();
        check("R4 flag before reset", {1'b0, flag}, 2'b01);
        do_reset();
        check("R4 reset clears flag", {1'b0, flag}, 2'b00);
    endtask

    // Scenario: depth-32 via size change, re-centre to 16, overflow drop
    task automatic t_depth32();
        do_reset();
        @(negedge clk) big = 1'b1;
        idle(2);
        for (int i = 0; i < 16; i++) wr(i[0], ~i[0]);
        check("R1 full at 32 flag", {1'b0, flag}, 2'b01);
        wr(1'b0, 1'b0);                         // dropped
        for (int i = 0; i < 16; i++) rd();
        for (int i = 0; i < 16; i++) begin
            rd();
            check("R6 R12 depth-32 order", {opos, oneg}, {i[0], ~i[0]});
        end
        rd();
        check("R7 overflow write not stored", {opos, oneg}, 2'b10);
        @(negedge clk) big = 1'b0;
        idle(2);
    endtask

    // Scenario: input and output edge selects
    task automatic t_edges();
        do_reset();
        in_rise = 1'b0;
        @(negedge clk) begin dpos = 1'b1; dneg = 1'b0; wclk = 1'b1; end
        idle(2);
        @(negedge clk) begin dpos = 1'b0; dneg = 1'b1; end
        @(negedge clk) wclk = 1'b0;
        idle(2);
        in_rise = 1'b1;
        @(negedge clk) begin dpos = 1'b1; dneg = 1'b1; wclk = 1'b1; end
        idle(2);
        @(negedge clk) begin dpos = 1'b0; dneg = 1'b0; end
        @(negedge clk) wclk = 1'b0;
        idle(2);
        for (int i = 0; i < 8; i++) rd();
        out_rise = 1'b0;
        @(negedge clk) rclk = 1'b1;
        idle(2);
        check("R11 falling mode: no change on rise", {opos, oneg}, 2'b00);
        check("R11 out_clk follows read clock", {1'b0, oclk}, 2'b01);
        @(negedge clk) rclk = 1'b0;
        idle(2);
        check("R10 falling capture, R11 falling update", {opos, oneg}, 2'b01);
        out_rise = 1'b1;
        @(negedge clk) rclk = 1'b1;
        idle(2);
        check("R10 rising capture, R11 rising update", {opos, oneg}, 2'b11);
        @(negedge clk) rclk = 1'b0;
        idle(2);
    endtask

    // Scenario: bypass path and frozen store
    task automatic t_bypass();
        do_reset();
        @(negedge clk) begin byp = 1'b1; dpos = 1'b1; dneg = 1'b0; wclk = 1'b1; end
        #1;
        check("R9 bypass data", {opos, oneg}, 2'b10);
        check("R9 bypass clock high", {1'b0, oclk}, 2'b01);
        dpos = 1'b0; dneg = 1'b1; wclk = 1'b0;
        #1;
        check("R9 bypass data follows", {opos, oneg}, 2'b01);
        check("R9 bypass clock low", {1'b0, oclk}, 2'b00);
        wr(1'b1, 1'b1);
        rd();
        @(negedge clk) byp = 1'b0;
        wr(1'b1, 1'b0);
        for (int i = 0; i < 8; i++) rd();
        check("R9 no entry removed in bypass", {opos, oneg}, 2'b00);
        rd();
        check("R9 no entry added in bypass", {opos, oneg}, 2'b10);
    endtask

    initial begin
        do_reset();
        t_depth16();
        t_flag_clear();
        t_depth32();
        t_edges();
        t_bypass();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule